// File: doc/BRIEF.md
# Programmable CRC Calculator

This block computes a cyclic redundancy check over a stream of 32-bit words that arrive through a small register interface, one access per clock. Software, or a memory-to-peripheral copy engine, writes message words into the data register, and each write advances the running checksum in a single cycle. Reading the same register returns the current result. The engine does not count words, so a message can be as long as needed, for example a full scan of program memory.

A control register sets the checksum width, which can be 16 or 32 bits. It also holds a seed-load switch and two independent reordering selectors: one applies to each incoming word, the other to the value that is read back. The generator polynomial sits in a writable register and is the standard 32-bit one after reset. To start a new message, software sets the seed-load switch, writes the start value into the data register, clears the switch, and then streams the data.

Access only works while the module clock enable is high. When the enable is low, an access produces an error response and has no effect on the block.

Top module: `crc_calc`

## Requirements
- R1: After reset, a data-register read returns 0xFFFFFFFF, the polynomial register reads 0x04C11DB7 and the control register reads 0x00000001.
- R2: Address map: 0 is data, 1 is polynomial, 2 is control, and address 3 reads 0 and ignores writes. Control field positions: bit 0 is width (1 = 32-bit, 0 = 16-bit), bit 1 is seed load, bits [5:4] are input reorder, bits [7:6] are output reorder. All other control bits read 0.
- R3: While seed load is 1, a data write stores the written word directly as the CRC state. In 16-bit mode only its low 16 bits are kept.
- R4: While seed load is 0, a data write advances the CRC over all 32 bits of the reordered word in one cycle, most significant bit first. For each bit, the feedback is state MSB XOR data bit, the state shifts left, and the polynomial is XORed in when the feedback is 1. With state 0 and polynomial P, the word 0x00000001 yields P.
- R5: In 16-bit mode only the low 16 bits of the polynomial and the state are used, the state MSB is bit 15, and a data read returns the result in bits [15:0] with bits [31:16] zero.
- R6: Input reorder codes: 0 leaves the word as is, 1 reverses the bits inside each byte, 2 reverses all 32 bits, 3 reverses the byte order.
- R7: Output reorder uses the same codes. In 32-bit mode it acts on the whole 32-bit result. In 16-bit mode it acts on the 16-bit result, where code 2 reverses 16 bits and code 3 swaps the two bytes.
- R8: An access with the clock enable low returns rsp_err = 1 and rsp_rdata = 0 in the same cycle, and changes no register.
- R9: Accumulation has no length limit. Any number of consecutive data writes each advance the state.
- R10: The polynomial register can be written with any 32-bit value, and the new value is used by the next data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Module clock enable; accesses are refused while low |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid in the same cycle as a read request |
| rsp_err | output | 1 | Access error: request made with the clock enable low |

## Verification
The assertions check on every cycle that refused accesses report an error, return zero and leave the state, polynomial and control untouched. They also check that seed writes land in the state exactly, that control and polynomial writes take effect on the next cycle, and that 16-bit reads keep the upper half clear. The actual checksum arithmetic depends on the reorder modes and on long word streams. Only the bench scenarios can show it, by comparing against a behavioural model and against fixed anchor values: a lone 1 bit fed in from a zero state must reproduce the polynomial.

// File: rtl/crc_pkg.sv
package crc_pkg;

  typedef enum logic [1:0] {
    XP_NONE  = 2'd0,
    XP_BITS  = 2'd1,
    XP_FULL  = 2'd2,
    XP_BYTES = 2'd3
  } xpose_e;

  typedef struct packed {
    logic [1:0] out_xp;
    logic [1:0] in_xp;
    logic [1:0] rsv;
    logic       seed_mode;
    logic       wide;
  } ctrl_t;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_POLY = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam logic [7:0] CTRL_RST  = 8'h01;
  localparam logic [7:0] CTRL_MASK = 8'hF3;

endpackage

// File: rtl/crc_rst_sync.sv
module crc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/crc_xpose.sv
module crc_xpose #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  input  logic [1:0]   code,
  output logic [W-1:0] dout
);
  import crc_pkg::*;

  localparam int NB = W / 8;

  logic [W-1:0] full_rev;
  logic [W-1:0] bit_rev;
  logic [W-1:0] byte_rev;

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam int BY = i / 8;
    localparam int BI = i % 8;
    assign full_rev[i] = din[W-1-i];
    assign bit_rev[i]  = din[BY*8 + 7 - BI];
    assign byte_rev[i] = din[(NB-1-BY)*8 + BI];
  end

  always_comb begin
    case (xpose_e'(code))
      XP_BITS:  dout = bit_rev;
      XP_FULL:  dout = full_rev;
      XP_BYTES: dout = byte_rev;
      default:  dout = din;
    endcase
  end

endmodule

// File: rtl/crc_step.sv
module crc_step #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] state,
  input  logic [DW-1:0] poly,
  input  logic [DW-1:0] data,
  input  logic          wide,
  output logic [DW-1:0] next
);

  localparam int HW = DW / 2;
  localparam logic [DW-1:0] LO_MASK = {{HW{1'b0}}, {HW{1'b1}}};

  logic [DW-1:0] c;
  logic [DW-1:0] p;
  logic          fb;

  always_comb begin
    c  = wide ? state : (state & LO_MASK);
    p  = wide ? poly  : (poly  & LO_MASK);
    fb = 1'b0;
    for (int i = DW-1; i >= 0; i--) begin
      fb = (wide ? c[DW-1] : c[HW-1]) ^ data[i];
      c  = {c[DW-2:0], 1'b0};
      if (fb) c = c ^ p;
      if (!wide) c = c & LO_MASK;
    end
    next = c;
  end

endmodule

// File: rtl/crc_calc.sv
module crc_calc #(
  parameter int              DW       = 32,
  parameter int              AW       = 2,
  parameter logic [DW-1:0]   POLY_RST = 32'h04C11DB7,
  parameter logic [DW-1:0]   SEED_RST = 32'hFFFFFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err
);
  import crc_pkg::*;

  localparam int HW = DW / 2;

  logic          rst_sync_n;
  logic [DW-1:0] crc_q, crc_d;
  logic [DW-1:0] poly_q, poly_d;
  ctrl_t         ctrl_q, ctrl_d;

  logic          acc, wr, rd;
  logic [DW-1:0] din_x;
  logic [DW-1:0] step_next;
  logic [DW-1:0] out_w;
  logic [HW-1:0] out_h;
  logic [DW-1:0] rd_mux;

  crc_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  crc_xpose #(.W(DW)) i_in_xp (
    .din  (req_wdata),
    .code (ctrl_q.in_xp),
    .dout (din_x)
  );

  crc_step #(.DW(DW)) i_step (
    .state (crc_q),
    .poly  (poly_q),
    .data  (din_x),
    .wide  (ctrl_q.wide),
    .next  (step_next)
  );

  crc_xpose #(.W(DW)) i_out_xp_w (
    .din  (crc_q),
    .code (ctrl_q.out_xp),
    .dout (out_w)
  );

  crc_xpose #(.W(HW)) i_out_xp_h (
    .din  (crc_q[HW-1:0]),
    .code (ctrl_q.out_xp),
    .dout (out_h)
  );

  assign acc = req_valid & clk_en;
  assign wr  = acc & req_write;
  assign rd  = acc & ~req_write;

  // next-state logic
  always_comb begin
    crc_d  = crc_q;
    poly_d = poly_q;
    ctrl_d = ctrl_q;
    if (wr) begin
      case (req_addr)
        ADDR_DATA: begin
          if (ctrl_q.seed_mode)
            crc_d = ctrl_q.wide ? req_wdata : {{HW{1'b0}}, req_wdata[HW-1:0]};
          else
            crc_d = step_next;
        end
        ADDR_POLY: poly_d = req_wdata;
        ADDR_CTRL: ctrl_d = ctrl_t'(req_wdata[7:0] & CTRL_MASK);
        default: ;
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      crc_q  <= SEED_RST;
      poly_q <= POLY_RST;
      ctrl_q <= ctrl_t'(CTRL_RST);
    end else begin
      crc_q  <= crc_d;
      poly_q <= poly_d;
      ctrl_q <= ctrl_d;
    end
  end

  // read path
  always_comb begin
    case (req_addr)
      ADDR_DATA: rd_mux = ctrl_q.wide ? out_w : {{HW{1'b0}}, out_h};
      ADDR_POLY: rd_mux = poly_q;
      ADDR_CTRL: rd_mux = {{(DW-8){1'b0}}, ctrl_q};
      default:   rd_mux = '0;
    endcase
  end

  assign rsp_rdata = rd ? rd_mux : '0;
  assign rsp_err   = req_valid & ~clk_en;

endmodule

// File: rtl/crc_calc_chk.sv
module crc_calc_chk #(
  parameter int DW = 32,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          clk_en,
  input logic          req_valid,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_wdata,
  input logic [DW-1:0] rsp_rdata,
  input logic          rsp_err,
  input logic [DW-1:0] crc_q,
  input logic [DW-1:0] poly_q,
  input logic [7:0]    ctrl_q
);

  a_r8_err_resp: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !clk_en) |-> (rsp_err && rsp_rdata == '0));

  a_r8_no_effect: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !clk_en) |=> ($stable(crc_q) && $stable(poly_q) && $stable(ctrl_q)));

  a_r3_seed_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clk_en && req_valid && req_write && req_addr == 2'd0 && ctrl_q[1] && ctrl_q[0])
    |=> (crc_q == $past(req_wdata)));

  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clk_en && req_valid && !req_write && req_addr == 2'd0 && !ctrl_q[0])
    |-> (rsp_rdata[DW-1:DW/2] == '0));

  a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clk_en && req_valid && req_write && req_addr == 2'd2)
    |=> (ctrl_q == ($past(req_wdata[7:0]) & 8'hF3)));

  a_r10_poly_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clk_en && req_valid && req_write && req_addr == 2'd1)
    |=> (poly_q == $past(req_wdata)));

endmodule

bind crc_calc crc_calc_chk #(.DW(DW), .AW(AW)) i_crc_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .clk_en     (clk_en),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_wdata  (req_wdata),
  .rsp_rdata  (rsp_rdata),
  .rsp_err    (rsp_err),
  .crc_q      (crc_q),
  .poly_q     (poly_q),
  .ctrl_q     (ctrl_q)
);

// File: tb/test_crc_calc.sv
`timescale 1ns/1ps
module test_crc_calc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_addr = 2'd0;
  logic [31:0] req_wdata = 32'd0;
  logic [31:0] rsp_rdata;
  logic        rsp_err;

  integer n_chk = 0;
  integer n_err = 0;
  logic [31:0] last_rd;

  // behavioural reference state
  logic [31:0] m_crc, m_poly;
  logic [7:0]  m_ctrl;

  always #5 clk = ~clk;

  crc_calc i_crc_calc (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] rev_n(input logic [31:0] v, input integer code, input integer w);
    logic [31:0] r;
    r = 32'd0;
    for (int k = 0; k < w; k++) begin
      case (code)
        1: r[k] = v[(k/8)*8 + (7 - k%8)];
        2: r[k] = v[w-1-k];
        3: r[k] = v[(w/8 - 1 - k/8)*8 + k%8];
        default: r[k] = v[k];
      endcase
    end
    return r;
  endfunction

  function automatic logic [31:0] m_step(input logic [31:0] c, input logic [31:0] p,
                                         input logic [31:0] d, input bit wide);
    integer w;
    logic [31:0] mask;
    bit top;
    w = wide ? 32 : 16;
    mask = wide ? 32'hFFFFFFFF : 32'h0000FFFF;
    c = c & mask;
    for (int k = 31; k >= 0; k--) begin
      top = c[w-1];
      c = (c << 1) & mask;
      if (top ^ d[k]) c = c ^ (p & mask);
    end
    return c;
  endfunction

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_ctrl[0] ? rev_n(m_crc, m_ctrl[7:6], 32)
                             : rev_n({16'd0, m_crc[15:0]}, m_ctrl[7:6], 16);
      2'd1: return m_poly;
      2'd2: return {24'd0, m_ctrl};
      default: return 32'd0;
    endcase
  endfunction

  task automatic m_write(input logic [1:0] a, input logic [31:0] d);
    case (a)
      2'd0: begin
        if (m_ctrl[1]) m_crc = m_ctrl[0] ? d : {16'd0, d[15:0]};
        else m_crc = m_step(m_crc, m_poly, rev_n(d, m_ctrl[5:4], 32), m_ctrl[0]);
      end
      2'd1: m_poly = d;
      2'd2: m_ctrl = d[7:0] & 8'hF3;
      default: ;
    endcase
  endtask

  // one access per clock; response sampled mid-cycle, model updated at the edge
  task automatic acc(input bit w, input logic [1:0] a, input logic [31:0] d,
                     input bit en, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; clk_en = en;
    #2;
    chk({31'd0, rsp_err}, {31'd0, ~en}, tag);
    if (!en) chk(rsp_rdata, 32'd0, tag);
    else if (!w) chk(rsp_rdata, m_read(a), tag);
    last_rd = rsp_rdata;
    @(posedge clk);
    if (w && en) m_write(a, d);
    #1;
    req_valid = 1'b0; clk_en = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
    acc(1'b1, a, d, 1'b1, tag);
    acc(1'b0, 2'd0, 32'd0, 1'b1, tag);
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    acc(1'b0, a, 32'd0, 1'b1, tag);
  endtask

  bit done = 1'b0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    m_crc = 32'hFFFFFFFF; m_poly = 32'h04C11DB7; m_ctrl = 8'h01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values, checked against fixed numbers
    rd(2'd0, "R1"); chk(last_rd, 32'hFFFFFFFF, "R1");
    rd(2'd1, "R1"); chk(last_rd, 32'h04C11DB7, "R1");
    rd(2'd2, "R1"); chk(last_rd, 32'h00000001, "R1");

    // R2 reserved control bits and unused address
    wr(2'd2, 32'hFFFFFF0C, "R2"); rd(2'd2, "R2"); chk(last_rd, 32'h0000000C & 32'hF3, "R2");
    wr(2'd3, 32'h12345678, "R2"); rd(2'd3, "R2"); chk(last_rd, 32'd0, "R2");

    // R3 seed load, R4 anchor: a single 1 bit from zero state yields the polynomial
    wr(2'd2, 32'h03, "R3"); wr(2'd0, 32'h00000000, "R3");
    rd(2'd0, "R3"); chk(last_rd, 32'h0, "R3");
    wr(2'd2, 32'h01, "R4"); wr(2'd0, 32'h00000001, "R4");
    rd(2'd0, "R4"); chk(last_rd, 32'h04C11DB7, "R4");
    wr(2'd2, 32'h03, "R3"); wr(2'd0, 32'hFFFFFFFF, "R3");
    rd(2'd0, "R3"); chk(last_rd, 32'hFFFFFFFF, "R3");
    wr(2'd2, 32'h01, "R4"); wr(2'd0, 32'h00260020, "R4");

    // R6 input reorder anchors: each word becomes 0x00000001 after reordering
    for (int code = 1; code < 4; code++) begin
      wr(2'd2, 32'h03, "R6"); wr(2'd0, 32'h0, "R6");
      wr(2'd2, 32'h01 | (code << 4), "R6");
      wr(2'd0, (code == 1) ? 32'h00000080 : (code == 2) ? 32'h80000000 : 32'h01000000, "R6");
      rd(2'd0, "R6"); chk(last_rd, 32'h04C11DB7, "R6");
    end

    // R7 output reorder of the value 1, 32-bit then 16-bit
    wr(2'd2, 32'h03, "R7"); wr(2'd0, 32'h00000001, "R7");
    wr(2'd2, 32'h41, "R7"); chk(last_rd, 32'h00000080, "R7");
    wr(2'd2, 32'h81, "R7"); chk(last_rd, 32'h80000000, "R7");
    wr(2'd2, 32'hC1, "R7"); chk(last_rd, 32'h01000000, "R7");
    wr(2'd2, 32'h82, "R7"); chk(last_rd, 32'h00008000, "R7");
    wr(2'd2, 32'hC2, "R7"); chk(last_rd, 32'h00000100, "R7");
    wr(2'd2, 32'h42, "R7"); chk(last_rd, 32'h00000080, "R7");

    // R5 16-bit mode: seed truncated, low polynomial half used, upper read half clear
    wr(2'd2, 32'h02, "R5"); wr(2'd0, 32'hABCD1234, "R5");
    rd(2'd0, "R5"); chk(last_rd, 32'h00001234, "R5");
    wr(2'd1, 32'hDEAD1021, "R10");
    wr(2'd0, 32'h0, "R5"); wr(2'd2, 32'h00, "R5");
    wr(2'd0, 32'h00000001, "R5"); chk(last_rd, 32'h00001021, "R5");
    wr(2'd0, 32'hCAFEF00D, "R5");

    // R8 refused accesses leave everything unchanged
    acc(1'b1, 2'd0, 32'h11111111, 1'b0, "R8");
    acc(1'b1, 2'd1, 32'h22222222, 1'b0, "R8");
    acc(1'b1, 2'd2, 32'h000000C3, 1'b0, "R8");
    acc(1'b0, 2'd1, 32'h0, 1'b0, "R8");
    rd(2'd0, "R8"); rd(2'd1, "R8"); chk(last_rd, 32'hDEAD1021, "R8");
    rd(2'd2, "R8"); chk(last_rd, 32'h00000000, "R8");

    // R10 polynomial change takes effect on the next data word
    wr(2'd1, 32'h04C11DB7, "R10");
    wr(2'd2, 32'h03, "R10"); wr(2'd0, 32'h0, "R10");
    wr(2'd2, 32'h01, "R10"); wr(2'd1, 32'h1EDC6F41, "R10");
    wr(2'd0, 32'h00000001, "R10"); chk(last_rd, 32'h1EDC6F41, "R10");
    wr(2'd1, 32'h04C11DB7, "R10");

    // R9 long stream under varying modes, compared to the model every cycle
    lf = 32'h1F2E3D4C;
    for (int blk = 0; blk < 8; blk++) begin
      wr(2'd2, {24'd0, 8'(blk * 37) & 8'hF1}, "R9");
      for (int k = 0; k < 300; k++) begin
        lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
        acc(1'b1, 2'd0, lf, 1'b1, "R9");
        rd(2'd0, "R9");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule